// File: doc/BRIEF.md
# Serial-Clock Activity Watchdog

This block guards against a lost host link. It watches a serial clock input for transitions. When none has arrived for a programmed number of system clock cycles (sized in a product for roughly 2.5 seconds), it pulls an active-low open-drain alarm line. In the same cycle it sends a one-cycle request that returns the configuration bits to their power-up state. That state switches off cell discharge and places the device in standby. The alarm line stays pulled until the serial clock moves again.

The serial clock passes through a two-flop synchronizer and then an edge detector. The detector counts both edges by default, or one polarity chosen by a parameter. Each detected edge restarts an idle counter. While the monitor-mode input is low, the watchdog is disabled. A separate synchronized copy of the alarm pin's actual level is presented for the configuration read-back bit (byte 0, bit 7). Because that bit shows the pin and not the internal state, a third party holding the pin low is visible to software. Such a pull does not cause a configuration reset.

Top module: `sclk_activity_wdog`

## Requirements
- R1: After reset `wd_pull_o` and `cfg_rst_pulse_o` are 0.
- R2: With the block enabled, if `sclk_i` last changed just after clock edge 0 and stays still, `wd_pull_o` rises at clock edge TIMEOUT_CYC+3. The 3 cycles are two synchronizer stages plus one detector stage. It does not rise earlier.
- R3: `cfg_rst_pulse_o` is high for exactly the one cycle in which `wd_pull_o` rises. It is not repeated while `wd_pull_o` stays high.
- R4: Once high, `wd_pull_o` stays high until a detected `sclk_i` edge. A change of `sclk_i` releases it at the third clock edge after the change.
- R5: Every detected edge restarts the idle count. Two `sclk_i` changes g clock cycles apart cause no timeout when g <= TIMEOUT_CYC. The case g = TIMEOUT_CYC is included, where the edge and the expiry fall on the same cycle and the edge wins. They cause exactly one timeout when g > TIMEOUT_CYC.
- R6: While `mon_mode_ni` is 0, `wd_pull_o` is released by the next clock edge and no timeout or pulse occurs. After `mon_mode_ni` returns to 1, the idle count starts from zero, and `wd_pull_o` rises TIMEOUT_CYC clock edges later if no edge arrives.
- R7: `cfg0_b7_o` equals `pin_lvl_i` delayed by two clock edges. Driving `pin_lvl_i` low never produces `cfg_rst_pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| mon_mode_ni | input | 1 | Low selects monitor mode and disables the watchdog |
| pin_lvl_i | input | 1 | Sampled level of the open-drain alarm pin |
| wd_pull_o | output | 1 | 1 = pull the alarm pin low (timed out) |
| cfg_rst_pulse_o | output | 1 | One-cycle configuration reset request |
| cfg0_b7_o | output | 1 | Synchronized pin level for configuration byte 0 bit 7 |

## Verification
A detected serial-clock edge and the expiry of the idle count can fall on the same clock cycle. The bench provokes this by sweeping the gap between two serial-clock changes from one cycle up past the limit. The gap equal to TIMEOUT_CYC makes the restart and the expiry collide. That gap must give neither a pulse nor an alarm. Every longer gap must give exactly one pulse, and the alarm must be released three cycles after the second change.

// File: rtl/wd_pkg.sv
package wd_pkg;
   typedef enum logic [1:0] {
      EDGE_BOTH = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2
   } wd_edge_e;
endpackage

// File: rtl/wd_sync.sv
module wd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= 1'b0;
            else         chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= 1'b0;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wd_edge_det.sv
module wd_edge_det
   import wd_pkg::*;
#(
   parameter wd_edge_e EDGE_MODE = EDGE_BOTH
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic edge_o
);
   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i;
   end

   if (EDGE_MODE == EDGE_RISE) begin : g_rise
      assign edge_o = lvl_i & ~prev_q;
   end else if (EDGE_MODE == EDGE_FALL) begin : g_fall
      assign edge_o = ~lvl_i & prev_q;
   end else begin : g_both
      assign edge_o = lvl_i ^ prev_q;
   end
endmodule

// File: rtl/wd_idle_timer.sv
module wd_idle_timer #(
   parameter int TIMEOUT_CYC = 125_000_000,
   localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic          edge_i,
   output logic          expired_o,
   output logic          fire_o,
   output logic [CW-1:0] cnt_o
);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("wd_idle_timer: TIMEOUT_CYC must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          expired_q;
   logic          fire_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q     <= '0;
         expired_q <= 1'b0;
         fire_q    <= 1'b0;
      end else if (!en_i || edge_i) begin
         cnt_q     <= '0;
         expired_q <= 1'b0;
         fire_q    <= 1'b0;
      end else if (!expired_q) begin
         if (cnt_q == LAST) begin
            expired_q <= 1'b1;
            fire_q    <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
            fire_q <= 1'b0;
         end
      end else begin
         fire_q <= 1'b0;
      end
   end

   assign expired_o = expired_q;
   assign fire_o    = fire_q;
   assign cnt_o     = cnt_q;
endmodule

// File: rtl/sclk_activity_wdog.sv
module sclk_activity_wdog
   import wd_pkg::*;
#(
   parameter int       TIMEOUT_CYC = 125_000_000,
   parameter int       SYNC_STAGES = 2,
   parameter wd_edge_e EDGE_MODE   = EDGE_BOTH,
   localparam int      CW          = $clog2(TIMEOUT_CYC + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sclk_i,
   input  logic mon_mode_ni,
   input  logic pin_lvl_i,
   output logic wd_pull_o,
   output logic cfg_rst_pulse_o,
   output logic cfg0_b7_o
);
   logic          sclk_s;
   logic          sclk_edge;
   logic [CW-1:0] idle_cnt;

   wd_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (sclk_i),
      .q_o   (sclk_s)
   );

   wd_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_lvl_i),
      .q_o   (cfg0_b7_o)
   );

   wd_edge_det #(.EDGE_MODE(EDGE_MODE)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (sclk_s),
      .edge_o(sclk_edge)
   );

   wd_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (mon_mode_ni),
      .edge_i   (sclk_edge),
      .expired_o(wd_pull_o),
      .fire_o   (cfg_rst_pulse_o),
      .cnt_o    (idle_cnt)
   );
endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
   parameter int  TIMEOUT_CYC = 125_000_000,
   localparam int CW          = $clog2(TIMEOUT_CYC + 1)
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          mon_mode_ni,
   input logic          sclk_edge,
   input logic          wd_pull_o,
   input logic          cfg_rst_pulse_o,
   input logic [CW-1:0] idle_cnt
);
   // R3
   pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_rst_pulse_o |=> !cfg_rst_pulse_o);

   // R3
   pulse_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wd_pull_o) |-> cfg_rst_pulse_o);

   // R3
   pulse_needs_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_rst_pulse_o |-> wd_pull_o);

   // R4
   hold_until_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wd_pull_o && !sclk_edge && mon_mode_ni) |=> wd_pull_o);

   // R4
   edge_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wd_pull_o && sclk_edge) |=> !wd_pull_o);

   // R5
   edge_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sclk_edge |=> (idle_cnt == '0) && !cfg_rst_pulse_o);

   // R6
   monitor_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mon_mode_ni |=> !wd_pull_o && !cfg_rst_pulse_o);

   // R2
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_cnt < CW'(TIMEOUT_CYC));
endmodule

bind sclk_activity_wdog wd_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd_checker (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .mon_mode_ni    (mon_mode_ni),
   .sclk_edge      (sclk_edge),
   .wd_pull_o      (wd_pull_o),
   .cfg_rst_pulse_o(cfg_rst_pulse_o),
   .idle_cnt       (idle_cnt)
);

// File: tb/test_sclk_activity_wdog.sv
module test_sclk_activity_wdog;
   localparam int LIM = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic mon_n = 1'b1;
   logic pin = 1'b1;
   logic pull, pulse, rb;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sclk_activity_wdog #(.TIMEOUT_CYC(LIM)) i_sclk_activity_wdog (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .sclk_i         (sclk),
      .mon_mode_ni    (mon_n),
      .pin_lvl_i      (pin),
      .wd_pull_o      (pull),
      .cfg_rst_pulse_o(pulse),
      .cfg0_b7_o      (rb)
   );

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pulse) pulses++;
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 pull", pull, 0);
      chk("R1 pulse", pulse, 0);

      // R2 / R3: idle from a fresh change
      sclk = ~sclk;
      pulses = 0;
      step(LIM + 2);
      chk("R2 early", pull, 0);
      chk("R3 no early pulse", pulses, 0);
      step(1);
      chk("R2 rise", pull, 1);
      chk("R3 pulse with rise", pulse, 1);
      step(1);
      chk("R3 pulse ends", pulse, 0);
      pulses = 0;
      step(3 * LIM);
      chk("R4 held", pull, 1);
      chk("R3 not repeated", pulses, 0);

      // R4 release timing
      sclk = ~sclk;
      step(2);
      chk("R4 still held", pull, 1);
      step(1);
      chk("R4 released", pull, 0);

      // R5 gap sweep, including the collision at g == LIM
      for (int g = 1; g <= LIM + 4; g++) begin
         sclk = ~sclk;
         pulses = 0;
         step(g);
         sclk = ~sclk;
         step(3);
         chk($sformatf("R5 gap %0d pulses", g), pulses, (g > LIM) ? 1 : 0);
         chk($sformatf("R5 gap %0d pull", g), pull, 0);
      end

      // R7 read-back follows pin, no reset from external pull
      sclk = ~sclk;
      pin = 1'b0;
      pulses = 0;
      step(1);
      chk("R7 rb lag", rb, 1);
      step(1);
      chk("R7 rb low", rb, 0);
      step(4);
      chk("R7 no pulse from pin", pulses, 0);
      pin = 1'b1;
      step(2);
      chk("R7 rb high", rb, 1);

      // R6 monitor mode: reach timeout, then disable
      step(LIM + 2);
      chk("R6 timed out first", pull, 1);
      mon_n = 1'b0;
      pulses = 0;
      step(1);
      chk("R6 released", pull, 0);
      step(LIM + 10);
      chk("R6 stays off", pull, 0);
      chk("R6 no pulse", pulses, 0);
      mon_n = 1'b1;
      step(LIM - 1);
      chk("R6 restart early", pull, 0);
      step(1);
      chk("R6 restart expiry", pull, 1);
      chk("R6 restart pulse", pulses, 1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule